// File: doc/BRIEF.md
# Counter-Addressed Tri-State Pin Bank

This block controls a bank of output pins through a handful of control inputs instead of a parallel address bus. An internal pointer names one pin at a time. A synchronous clear sends the pointer back to pin 0 and floats every pin. An advance strobe moves the pointer forward by one pin. A write strobe records a requested state in the pin the pointer names. That state is drive-high, drive-low or float.

Each pin keeps two stored bits: a data bit and an output-enable bit. The pad view is built from these bits. A pin with its enable set carries its data bit, and a pin with its enable clear is high impedance. A controller walks the bank by pulsing clear once, then giving write and advance strobes in turn. Write and advance may come in the same cycle, so one pin can be written per cycle.

Top module: `tri_pin_bank`

## Requirements
- R1: After reset or after a cycle with `clr` high, `sel_ptr` is 0 and every bit of `pin_oe` and `pin_dat` is 0, so all of `pad` is Z.
- R2: With `clr` low and `adv` high, `sel_ptr` increases by exactly one at the next rising edge.
- R3: `clr` takes priority over `adv` and over `wr` in the same cycle: the pointer becomes 0, every pin floats, and the write is dropped.
- R4: With `clr` low and `adv` low, `sel_ptr` keeps its value.
- R5: A write with `req_float` = 1 clears the selected pin's `pin_oe` bit and its `pin_dat` bit.
- R6: A write with `req_float` = 0 sets the selected pin's `pin_oe` bit and stores `req_dat` in its `pin_dat` bit.
- R7: A write changes only the pin at index `sel_ptr`. Every other pin keeps both of its stored bits, and no pin changes in a cycle without `wr` or `clr`.
- R8: An advance from pin 31 (NUM_PINS-1) wraps the pointer to 0.
- R9: When `wr` and `adv` are high in the same cycle, the write targets the pin the pointer named before the increment.
- R10: `pad[i]` equals `pin_dat[i]` when `pin_oe[i]` is 1, and is Z when `pin_oe[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all storage updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the pointer and all pins |
| adv | input | 1 | Advance the pointer by one pin |
| wr | input | 1 | Store the requested state into the selected pin |
| req_float | input | 1 | Requested state is float (1) or drive (0) |
| req_dat | input | 1 | Level to drive when req_float is 0 |
| sel_ptr | output | 5 | Current pin pointer |
| pin_dat | output | 32 | Stored data bit per pin |
| pin_oe | output | 32 | Stored output-enable bit per pin |
| pad | output | 32 | Pad view: data where enabled, Z elsewhere |

## Verification
Three actions can land in the same cycle: a write, an advance and a clear. Write with advance is the combination that matters. The bench forces it on purpose at pin 31, where the pointer wraps, and also fires it at random. After the edge it checks that only the pin named before the increment changed, and that the pointer moved on. Clear is also mixed in together with both strobes. The bench then expects the write to be lost and the whole bank to float.

// File: rtl/tri_pin_bank_pkg.sv
package tri_pin_bank_pkg;

    // Requested state for one pin, as given on the write strobe.
    typedef struct packed {
        logic flt;
        logic dat;
    } pin_req_t;

    // Stored state of one pin.
    typedef struct packed {
        logic oe;
        logic dat;
    } pin_state_t;

endpackage

// File: rtl/tri_pin_bank_pointer.sv
module tri_pin_bank_pointer #(
    parameter int NUM_PINS = 32,
    localparam int PTR_W   = $clog2(NUM_PINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_PINS - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_regs_t;

    ptr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.ptr = '0;
        end else if (adv) begin
            r_d.ptr = (r_q.ptr == LAST) ? '0 : r_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ptr = r_q.ptr;

    // R2: a single step forward away from the wrap point
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
    // R3: clear wins over advance
    a_r3_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr == '0));
    // R4: no strobe, no movement
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(ptr));
    // R8: wrap from the last pin
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv && ptr == LAST) |=> (ptr == '0));

endmodule

// File: rtl/tri_pin_bank_cell.sv
module tri_pin_bank_cell
    import tri_pin_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     hit,
    input  pin_req_t req,
    output logic     oe,
    output logic     dat
);
    pin_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (hit) begin
            s_d.oe  = ~req.flt;
            s_d.dat = req.flt ? 1'b0 : req.dat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign oe  = s_q.oe;
    assign dat = s_q.dat;

    // R5: a float request releases the pin
    a_r5_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && hit && req.flt) |=> (!oe && !dat));
    // R6: a drive request enables the pin with the given level
    a_r6_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && hit && !req.flt) |=> (oe && dat == $past(req.dat)));
    // R7: a pin that is not addressed keeps its state
    a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hit) |=> ($stable(oe) && $stable(dat)));
    // R1: clear floats the pin
    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!oe && !dat));

endmodule

// File: rtl/tri_pin_bank_pad.sv
module tri_pin_bank_pad #(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] dat,
    input  logic [NUM_PINS-1:0] oe,
    output logic [NUM_PINS-1:0] pad
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
        assign pad[i] = oe[i] ? dat[i] : 1'bz;
    end
endmodule

// File: rtl/tri_pin_bank.sv
module tri_pin_bank
    import tri_pin_bank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    localparam int PTR_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                adv,
    input  logic                wr,
    input  logic                req_float,
    input  logic                req_dat,
    output logic [PTR_W-1:0]    sel_ptr,
    output logic [NUM_PINS-1:0] pin_dat,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pad
);
    pin_req_t            req;
    logic [NUM_PINS-1:0] hit;

    assign req.flt = req_float;
    assign req.dat = req_dat;

    tri_pin_bank_pointer #(.NUM_PINS(NUM_PINS)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .adv   (adv),
        .ptr   (sel_ptr)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
        assign hit[i] = wr && (sel_ptr == PTR_W'(i));

        tri_pin_bank_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .hit   (hit[i]),
            .req   (req),
            .oe    (pin_oe[i]),
            .dat   (pin_dat[i])
        );
    end

    tri_pin_bank_pad #(.NUM_PINS(NUM_PINS)) u_pad (
        .dat (pin_dat),
        .oe  (pin_oe),
        .pad (pad)
    );

    // R9: at most one pin is addressed by a write, and it is the current pointer
    a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    // R10: an enabled pad follows its data bit
    a_r10_pad: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & pad) === (pin_oe & pin_dat)));

endmodule

// File: tb/tri_pin_bank_bench.sv
module tri_pin_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic clk = 0, rst_n = 0;
    logic clr = 0, adv = 0, wr = 0, req_float = 0, req_dat = 0;
    logic [4:0]   sel_ptr;
    logic [N-1:0] pin_dat, pin_oe, pad;

    int checks = 0, errors = 0;
    logic [4:0]   e_ptr = 0;
    logic [N-1:0] e_oe = 0, e_dat = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_pin_bank u_tri_pin_bank (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .wr(wr),
        .req_float(req_float), .req_dat(req_dat),
        .sel_ptr(sel_ptr), .pin_dat(pin_dat), .pin_oe(pin_oe), .pad(pad)
    );

    function automatic logic [N-1:0] exp_pad(logic [N-1:0] oe, logic [N-1:0] d);
        logic [N-1:0] p;
        for (int i = 0; i < N; i++) p[i] = oe[i] ? d[i] : 1'bz;
        return p;
    endfunction

    task automatic chk(string tag);
        checks++;
        if (sel_ptr !== e_ptr) begin
            errors++; $display("FAIL %s ptr actual=%0d expected=%0d", tag, sel_ptr, e_ptr);
        end
        checks++;
        if (pin_oe !== e_oe) begin
            errors++; $display("FAIL %s oe actual=%h expected=%h", tag, pin_oe, e_oe);
        end
        checks++;
        if (pin_dat !== e_dat) begin
            errors++; $display("FAIL %s dat actual=%h expected=%h", tag, pin_dat, e_dat);
        end
        checks++;
        if (pad !== exp_pad(e_oe, e_dat)) begin
            errors++; $display("FAIL R10 %s pad actual=%b expected=%b", tag, pad, exp_pad(e_oe, e_dat));
        end
    endtask

    // Drive one cycle, update the model, and check at the following falling edge.
    task automatic cyc(logic c, logic a, logic w, logic f, logic d, string tag);
        clr = c; adv = a; wr = w; req_float = f; req_dat = d;
        @(posedge clk);
        if (c) begin
            e_ptr = 0; e_oe = 0; e_dat = 0;
        end else begin
            if (w) begin
                e_oe[e_ptr]  = ~f;
                e_dat[e_ptr] = f ? 1'b0 : d;
            end
            if (a) e_ptr = e_ptr + 1'b1;
        end
        @(negedge clk);
        chk(tag);
    endtask

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        @(negedge clk); @(negedge clk);
        chk("R1 reset");
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset");

        cyc(0, 0, 1, 0, 1, "R6 drive high pin0");
        cyc(0, 1, 0, 0, 0, "R2 advance");
        cyc(0, 0, 1, 0, 0, "R6 drive low pin1");
        cyc(0, 0, 0, 0, 0, "R4 hold");
        cyc(0, 0, 1, 1, 1, "R5 float pin1");
        cyc(0, 1, 1, 0, 1, "R9 write plus advance");
        cyc(0, 0, 1, 0, 1, "R7 only pin2 changes");
        for (int i = 0; i < 29; i++) cyc(0, 1, 0, 0, 0, "R2 walk");
        cyc(0, 1, 1, 0, 1, "R8 R9 write at 31 and wrap");
        cyc(0, 1, 1, 0, 1, "R3 prep");
        cyc(1, 1, 1, 0, 1, "R3 clear beats advance and write");
        cyc(0, 0, 0, 0, 0, "R1 floated after clear");

        for (int i = 0; i < 3000; i++) begin
            logic c, a, w, f, d;
            c = ($urandom % 40) == 0;
            a = ($urandom % 3) != 0;
            w = ($urandom % 2) == 0;
            f = ($urandom % 4) == 0;
            d = $urandom % 2;
            cyc(c, a, w, f, d, "R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule